// File: doc/BRIEF.md
# Fetch Stall-Slack Predictor

This block sits beside the branch target buffer of an in-order core's fetch unit. For each fetch group it learns how many idle cycles the group can absorb before it would hold up dispatch, and it tells fetch to wait that many cycles before sending the group. Coarse dispatch stalls are thereby spread back into fetch as small per-group gaps, and a transparent fetch pipeline can use those gaps. Each table entry holds a tag, a 3-bit stall-cycle count and a 4-bit confidence counter. The table is set-associative, with pseudo-LRU replacement inside each set.

Fetch presents a group address together with a probe bit. The probe bit comes from an external random source and is high on about one lookup in ten. One cycle later the block returns a hit flag and the delay to apply. The delay is non-zero only when the entry is trusted and the lookup is not a probe, so the occurrences that run without inserted delay measure the real slack. Dispatch reports back the group address, the stall it measured and whether that occurrence ran unperturbed. Only unperturbed reports train the entry. The stored count settles to the smallest slack seen, and confidence counts how many agreeing observations followed.

Top module: `slack_pred`

## Requirements
- R1: While `rst` is high at a clock edge, the response outputs go to zero on that edge and every table entry becomes invalid, so the next lookup of any address misses.
- R2: A lookup sampled at one edge is answered on the next edge: `rsp_vld_o` is high exactly in the cycle after `lk_valid`. When no lookup was made, `rsp_hit_o` and `rsp_dly_o` are zero.
- R3: The set index is the low log2(SETS) bits of an address and the tag is the remaining upper bits. A lookup that misses answers hit 0 and delay 0. It then allocates an entry in its set with count 7 and confidence 0, taking the lowest-numbered invalid way if one exists.
- R4: A lookup that hits answers with the stored count only when confidence is greater than 4. At confidence 4 or lower the delay is 0.
- R5: A lookup with `lk_probe` high answers delay 0 even when the entry it hits is trusted, and `rsp_hit_o` is still 1.
- R6: An unperturbed observation that hits an entry, with measured stall not below the stored count, increments confidence, which saturates at 15.
- R7: An unperturbed observation that hits an entry, with measured stall below the stored count, replaces the count with the measurement and clears confidence to 0.
- R8: A measured stall above 7 is treated as 7.
- R9: An observation marked as perturbed (`obs_unpert` low), or one whose address is not in the table, changes nothing.
- R10: When a set has no invalid way, allocation evicts the way chosen by a binary-tree pseudo-LRU. Every lookup marks the way it hit or filled as most recent. Observations do not change the replacement state.
- R11: When a lookup and an observation address the same entry in the same cycle, the lookup answers from the entry as it was before the observation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Fetch-group lookup request |
| lk_pc | input | PC_W | Fetch-group address for the lookup |
| lk_probe | input | 1 | Random check: run this occurrence with no inserted delay |
| obs_valid | input | 1 | Dispatch-stall observation present |
| obs_pc | input | PC_W | Fetch-group address of the observation |
| obs_stall | input | MEAS_W | Measured dispatch stall cycles |
| obs_unpert | input | 1 | The observed occurrence ran with no inserted delay |
| rsp_vld_o | output | 1 | Response to the previous cycle's lookup |
| rsp_hit_o | output | 1 | The lookup found its group in the table |
| rsp_dly_o | output | 3 | Cycles of delay fetch inserts before the group |

## Verification
Two functions can fall in the same cycle: a fetch lookup reading an entry, and a dispatch observation rewriting that same entry. The bench provokes this with a trusted entry of count 3. In one cycle it looks that entry up and reports a smaller measured stall for it. It then expects the response to carry the old count 3, and expects the following lookup to return delay 0 because confidence was cleared. Whether replacement is driven only by lookups is judged separately. An observation placed between fills must leave the eviction choice unchanged.

// File: rtl/slack_pkg.sv
package slack_pkg;
  localparam int CNT_W     = 3;
  localparam int CONF_W    = 4;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [CONF_W-1:0] CONF_MAX  = '1;
  localparam logic [CONF_W-1:0] CONF_GATE = 4'd4;
endpackage

// File: rtl/slack_match.sv
module slack_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [WAYS-1:0]            row_vld,
  input  logic [TAG_W-1:0]           tag_in,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = row_vld[w] && (row_tag[w] == tag_in);
  end

  always_comb begin
    hit = |eq;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/slack_train.sv
module slack_train
  import slack_pkg::*;
#(
  parameter int MEAS_W = 4
) (
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic [CONF_W-1:0] cur_conf,
  input  logic [MEAS_W-1:0] meas,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic [CONF_W-1:0] nxt_conf
);
  logic [CNT_W-1:0] m_sat;

  always_comb begin
    m_sat = (meas > MEAS_W'(CNT_MAX)) ? CNT_MAX : meas[CNT_W-1:0];
    if (m_sat >= cur_cnt) begin
      nxt_cnt  = cur_cnt;
      nxt_conf = (cur_conf == CONF_MAX) ? CONF_MAX : cur_conf + 1'b1;
    end else begin
      nxt_cnt  = m_sat;
      nxt_conf = '0;
    end
  end
endmodule

// File: rtl/slack_plru.sv
module slack_plru #(
  parameter int SETS = 256,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [WAYS-1:0]  rd_vld,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  logic [NODES-1:0] tree_q [SETS];

  function automatic logic [WAY_W-1:0] tree_pick(input logic [NODES-1:0] t);
    int node = 0;
    for (int l = 0; l < WAY_W; l++) node = 2 * node + 1 + int'(t[node]);
    return WAY_W'(node - NODES);
  endfunction

  function automatic logic [NODES-1:0] tree_mark(input logic [NODES-1:0] t,
                                                 input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r = t;
    int node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      r[node] = ~w[WAY_W-1-l];
      node    = 2 * node + 1 + int'(w[WAY_W-1-l]);
    end
    return r;
  endfunction

  always_comb begin
    victim = tree_pick(tree_q[rd_set]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!rd_vld[w]) victim = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[rd_set] <= tree_mark(tree_q[rd_set], touch_way);
    end
  end
endmodule

// File: rtl/slack_pred.sv
module slack_pred
  import slack_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int MEAS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic              lk_probe,
  input  logic              obs_valid,
  input  logic [PC_W-1:0]   obs_pc,
  input  logic [MEAS_W-1:0] obs_stall,
  input  logic              obs_unpert,
  output logic              rsp_vld_o,
  output logic              rsp_hit_o,
  output logic [CNT_W-1:0]  rsp_dly_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]   vld_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q  [SETS][WAYS];
  logic [CONF_W-1:0] conf_q [SETS][WAYS];

  logic [IDX_W-1:0] l_set, o_set;
  logic [TAG_W-1:0] l_tag, o_tag;
  logic [WAYS-1:0][TAG_W-1:0] l_row, o_row;
  logic             l_hit, o_hit;
  logic [WAY_W-1:0] l_way, o_way, victim, touch_way;
  logic [CNT_W-1:0]  n_cnt;
  logic [CONF_W-1:0] n_conf;
  logic              trusted, do_train, do_fill;

  assign l_set = lk_pc[IDX_W-1:0];
  assign l_tag = lk_pc[PC_W-1:IDX_W];
  assign o_set = obs_pc[IDX_W-1:0];
  assign o_tag = obs_pc[PC_W-1:IDX_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      l_row[w] = tag_q[l_set][w];
      o_row[w] = tag_q[o_set][w];
    end
  end

  slack_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .row_tag(l_row), .row_vld(vld_q[l_set]), .tag_in(l_tag),
    .hit(l_hit), .way(l_way)
  );

  slack_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_obs_match (
    .row_tag(o_row), .row_vld(vld_q[o_set]), .tag_in(o_tag),
    .hit(o_hit), .way(o_way)
  );

  slack_train #(.MEAS_W(MEAS_W)) u_train (
    .cur_cnt(cnt_q[o_set][o_way]), .cur_conf(conf_q[o_set][o_way]),
    .meas(obs_stall), .nxt_cnt(n_cnt), .nxt_conf(n_conf)
  );

  assign touch_way = l_hit ? l_way : victim;

  slack_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst(rst), .rd_set(l_set), .rd_vld(vld_q[l_set]),
    .touch_en(lk_valid), .touch_way(touch_way), .victim(victim)
  );

  assign trusted  = conf_q[l_set][l_way] > CONF_GATE;
  assign do_train = obs_valid && obs_unpert && o_hit;
  assign do_fill  = lk_valid && !l_hit;

  // Entry payload: no reset, written like a RAM; a fill overrides a training
  // write to the same way in the same cycle.
  always_ff @(posedge clk) begin
    if (do_train) begin
      cnt_q[o_set][o_way]  <= n_cnt;
      conf_q[o_set][o_way] <= n_conf;
    end
    if (do_fill) begin
      tag_q[l_set][victim]  <= l_tag;
      cnt_q[l_set][victim]  <= CNT_MAX;
      conf_q[l_set][victim] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (do_fill) begin
      vld_q[l_set][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld_o <= 1'b0;
      rsp_hit_o <= 1'b0;
      rsp_dly_o <= '0;
    end else begin
      rsp_vld_o <= lk_valid;
      rsp_hit_o <= lk_valid && l_hit;
      rsp_dly_o <= (lk_valid && l_hit && trusted && !lk_probe) ?
                   cnt_q[l_set][l_way] : '0;
    end
  end
endmodule

// File: rtl/slack_pred_chk.sv
module slack_pred_chk (
  input logic       clk,
  input logic       rst,
  input logic       lk_valid,
  input logic       lk_probe,
  input logic       rsp_vld_o,
  input logic       rsp_hit_o,
  input logic [2:0] rsp_dly_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rsp_vld_o && !rsp_hit_o && rsp_dly_o == 3'd0));

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_vld_o);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_vld_o && !rsp_hit_o && rsp_dly_o == 3'd0));

  assert_miss_no_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld_o && !rsp_hit_o) |-> rsp_dly_o == 3'd0);

  assert_probe_no_delay_R5: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_probe) |=> rsp_dly_o == 3'd0);
endmodule

bind slack_pred slack_pred_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_probe(lk_probe),
  .rsp_vld_o(rsp_vld_o), .rsp_hit_o(rsp_hit_o), .rsp_dly_o(rsp_dly_o)
);

// File: tb/test_slack_pred.sv
`timescale 1ns/1ps
module test_slack_pred;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_probe = 1'b0;
  logic [15:0] lk_pc = '0, obs_pc = '0;
  logic        obs_valid = 1'b0, obs_unpert = 1'b0;
  logic [3:0]  obs_stall = '0;
  logic        rsp_vld_o, rsp_hit_o;
  logic [2:0]  rsp_dly_o;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  slack_pred i_slack_pred (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_probe(lk_probe),
    .obs_valid(obs_valid), .obs_pc(obs_pc), .obs_stall(obs_stall),
    .obs_unpert(obs_unpert), .rsp_vld_o(rsp_vld_o), .rsp_hit_o(rsp_hit_o),
    .rsp_dly_o(rsp_dly_o)
  );

  typedef struct packed {
    logic        lk;  logic [15:0] lpc; logic pr;
    logic        up;  logic [15:0] upc; logic [3:0] m; logic unp;
    logic        ehit; logic [2:0] edly; logic [3:0] req;
  } vec_t;

  localparam logic [15:0] PA = 16'h0105, PF = 16'h0605, PG = 16'h0705;

  localparam vec_t VEC [24] = '{
    '{1'b1, PA, 1'b0, 1'b0, 16'h0, 4'd0,  1'b0, 1'b0, 3'd0, 4'd3},  // R3 miss, fill
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd3,  1'b1, 1'b0, 3'd0, 4'd7},  // R7 count 7 -> 3
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd3,  1'b1, 1'b0, 3'd0, 4'd6},
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd3,  1'b1, 1'b0, 3'd0, 4'd6},
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd3,  1'b1, 1'b0, 3'd0, 4'd6},  // conf 3
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd3,  1'b1, 1'b0, 3'd0, 4'd6},  // conf 4
    '{1'b1, PA, 1'b0, 1'b0, 16'h0, 4'd0,  1'b0, 1'b1, 3'd0, 4'd4},  // R4 conf 4 gives 0
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd3,  1'b1, 1'b0, 3'd0, 4'd6},  // conf 5
    '{1'b1, PA, 1'b0, 1'b0, 16'h0, 4'd0,  1'b0, 1'b1, 3'd3, 4'd4},  // R4 trusted
    '{1'b1, PA, 1'b1, 1'b0, 16'h0, 4'd0,  1'b0, 1'b1, 3'd0, 4'd5},  // R5 probe
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd1,  1'b0, 1'b0, 3'd0, 4'd9},  // R9 perturbed
    '{1'b1, PA, 1'b0, 1'b0, 16'h0, 4'd0,  1'b0, 1'b1, 3'd3, 4'd9},
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd5,  1'b1, 1'b0, 3'd0, 4'd6},  // R6 above count
    '{1'b1, PA, 1'b0, 1'b0, 16'h0, 4'd0,  1'b0, 1'b1, 3'd3, 4'd6},
    '{1'b0, 16'h0, 1'b0, 1'b1, PA, 4'd2,  1'b1, 1'b0, 3'd0, 4'd7},  // R7 below count
    '{1'b1, PA, 1'b0, 1'b0, 16'h0, 4'd0,  1'b0, 1'b1, 3'd0, 4'd7},
    '{1'b0, 16'h0, 1'b0, 1'b1, PF, 4'd1,  1'b1, 1'b0, 3'd0, 4'd9},  // R9 absent
    '{1'b1, PF, 1'b0, 1'b0, 16'h0, 4'd0,  1'b0, 1'b0, 3'd0, 4'd9},
    '{1'b1, PG, 1'b0, 1'b0, 16'h0, 4'd0,  1'b0, 1'b0, 3'd0, 4'd3},
    '{1'b0, 16'h0, 1'b0, 1'b1, PG, 4'd10, 1'b1, 1'b0, 3'd0, 4'd8},  // R8 10 -> 7
    '{1'b0, 16'h0, 1'b0, 1'b1, PG, 4'd10, 1'b1, 1'b0, 3'd0, 4'd8},
    '{1'b0, 16'h0, 1'b0, 1'b1, PG, 4'd10, 1'b1, 1'b0, 3'd0, 4'd8},
    '{1'b0, 16'h0, 1'b0, 1'b1, PG, 4'd10, 1'b1, 1'b0, 3'd0, 4'd8},
    '{1'b0, 16'h0, 1'b0, 1'b1, PG, 4'd10, 1'b1, 1'b0, 3'd0, 4'd8}
  };

  task automatic step(input logic lk, input logic [15:0] lpc, input logic pr,
                      input logic up, input logic [15:0] upc,
                      input logic [3:0] m, input logic unp);
    lk_valid = lk; lk_pc = lpc; lk_probe = pr;
    obs_valid = up; obs_pc = upc; obs_stall = m; obs_unpert = unp;
    @(negedge clk);
  endtask

  task automatic look(input logic [15:0] pc);
    step(1'b1, pc, 1'b0, 1'b0, 16'h0, 4'd0, 1'b0);
  endtask

  task automatic teach(input logic [15:0] pc, input logic [3:0] m, input int times);
    for (int k = 0; k < times; k++) step(1'b0, 16'h0, 1'b0, 1'b1, pc, m, 1'b1);
  endtask

  task automatic expect_rsp(input string req, input logic vld, input logic hit,
                            input logic [2:0] dly);
    n_run++;
    if (rsp_vld_o !== vld || rsp_hit_o !== hit || rsp_dly_o !== dly) begin
      n_fail++;
      $display("FAIL %s: got vld=%b hit=%b dly=%0d, expected vld=%b hit=%b dly=%0d",
               req, rsp_vld_o, rsp_hit_o, rsp_dly_o, vld, hit, dly);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_rsp("R1 reset outputs", 1'b0, 1'b0, 3'd0);
    rst = 1'b0;

    // Vector table: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 24; i++) begin
      step(VEC[i].lk, VEC[i].lpc, VEC[i].pr, VEC[i].up, VEC[i].upc, VEC[i].m, VEC[i].unp);
      if (VEC[i].lk)
        expect_rsp($sformatf("R%0d row %0d", VEC[i].req, i), 1'b1, VEC[i].ehit, VEC[i].edly);
    end
    look(PG);
    expect_rsp("R8 saturated measurement", 1'b1, 1'b1, 3'd7);
    step(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 4'd0, 1'b0);
    expect_rsp("R2 idle cycle", 1'b0, 1'b0, 3'd0);

    // R1: reset empties the table
    rst = 1'b1;
    step(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 4'd0, 1'b0);
    step(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 4'd0, 1'b0);
    rst = 1'b0;
    look(PA);
    expect_rsp("R1 table empty after reset", 1'b1, 1'b0, 3'd0);

    // R10: full set, observation between fills must not move the victim
    look(16'h0109); teach(16'h0109, 4'd3, 6);
    look(16'h0109);
    expect_rsp("R10 trained way0", 1'b1, 1'b1, 3'd3);
    look(16'h0209); look(16'h0309);
    teach(16'h0109, 4'd3, 1);
    look(16'h0409);
    look(16'h0509);
    expect_rsp("R10 fill on full set", 1'b1, 1'b0, 3'd0);
    look(16'h0109);
    expect_rsp("R10 least recent evicted", 1'b1, 1'b0, 3'd0);

    // R10: re-touched way survives, way2 is evicted instead
    look(16'h010A); teach(16'h010A, 4'd3, 6);
    look(16'h020A); look(16'h030A); look(16'h040A);
    look(16'h010A);
    expect_rsp("R10 touch hit", 1'b1, 1'b1, 3'd3);
    look(16'h050A);
    look(16'h010A);
    expect_rsp("R10 recent way kept", 1'b1, 1'b1, 3'd3);
    look(16'h030A);
    expect_rsp("R10 way2 evicted", 1'b1, 1'b0, 3'd0);

    // R6: confidence saturates at 15 instead of wrapping
    look(16'h0111); teach(16'h0111, 4'd3, 21);
    look(16'h0111);
    expect_rsp("R6 confidence saturates", 1'b1, 1'b1, 3'd3);

    // R11: lookup and observation on the same entry in one cycle
    step(1'b1, 16'h0111, 1'b0, 1'b1, 16'h0111, 4'd1, 1'b1);
    expect_rsp("R11 lookup sees old entry", 1'b1, 1'b1, 3'd3);
    look(16'h0111);
    expect_rsp("R7 reset confidence after collision", 1'b1, 1'b1, 3'd0);

    step(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 4'd0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule